// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block is the register file that a host CPU sees on a tile-based video processor. The CPU reaches eight byte-wide registers through a 3-bit index, a read strobe, a write strobe and an 8-bit data bus. The block keeps:

- the control and mask bytes;
- a 15-bit staging address and the 15-bit live video-memory address;
- the 3-bit fine horizontal scroll;
- a shared first/second write toggle for the two double-write registers;
- a one-byte read-ahead buffer for the memory data port;
- three status flags.

An external timing generator gives single-cycle pulses at the start and at the end of vertical blank. The sprite logic gives single-cycle pulses that set the sprite-zero hit flag and the sprite overflow flag.

After reset the block holds a start-up lock until the first end-of-blank pulse. While the lock is held, the configuration registers stay cleared and writes to them are dropped. This holds the control, mask, scroll and address registers. The status, sprite-memory and data-port registers work from the first cycle after reset.

The live address, the staging address, fine scroll, control and mask drive the renderer directly. The data bus (`wrData`) goes straight to the video memory and to the sprite memory, and `vramWe` and `oamWe` qualify it. Read and write strobes are expected one at a time. If both are high in the same cycle, only the read acts.

Top module: `vid_reg_port`

## Requirements
- R1: After reset, `holdActive` is 1. The first `vblankEnd` pulse clears it, and it stays 0 until the next reset.
- R2: While `holdActive` is 1, `ctrlOut`, `maskOut`, `tempAddr`, `fineX` and the read buffer stay 0. Writes to index 0 (control), 1 (mask), 5 (scroll) and 6 (address) have no effect, and the write toggle stays at "first write". A data-port read therefore returns 0.
- R3: While `holdActive` is 1, the following accesses act normally:
  - index 2 (status) reads;
  - index 3 (sprite address) writes;
  - index 4 (sprite data) accesses;
  - index 7 (data port) accesses, including the address step.
- R4: Reset does not change `vramAddr`, and neither does the start-up lock.
- R5: Each of the following pulses sets its flag:
  - `vblankStart` sets the blank flag;
  - `spr0HitSet` sets the hit flag;
  - `sprOvfSet` sets the overflow flag.

  `vblankEnd` clears all three flags. If a set pulse and a clear act on a flag in the same cycle, the set wins.
- R6: A read of index 2 returns blank in bit 7, hit in bit 6, overflow in bit 5 and zeros in bits 4:0. The read then clears the blank flag only, and returns the write toggle to "first write".
- R7: Scroll (index 5) writes:
  - The first write loads `tempAddr[4:0]` from data[7:3] and `fineX` from data[2:0].
  - The second write loads `tempAddr[9:5]` from data[7:3] and `tempAddr[14:12]` from data[2:0].
  - The other bits of `tempAddr` are kept.
- R8: Address (index 6) writes:
  - The first write loads `tempAddr[13:8]` from data[5:0] and clears `tempAddr[14]`.
  - The second write loads `tempAddr[7:0]` and copies the full new value into `vramAddr`.
- R9: A read of index 7 does three things:
  - it returns the buffer contents from before the read;
  - it loads the buffer with `vramRdData`;
  - it steps `vramAddr` by 1 when control bit 2 is 0, and by 32 when control bit 2 is 1, wrapping at 15 bits.
- R10: A write to index 7 raises `vramWe` for that cycle and steps `vramAddr` in the same way as R9.
- R11: `nmiOut` is 1 exactly when the blank flag is set and control bit 7 is set.
- R12: Sprite-memory registers:
  - A write to index 3 loads `oamAddr`.
  - A write to index 4 raises `oamWe` for that cycle and then increments `oamAddr`.
  - A read of index 4 returns `oamRdData` and leaves `oamAddr` unchanged.
  - Reads of indices 0, 1, 3, 5 and 6 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regIdx | input | 3 | Register index |
| rdStb | input | 1 | Read strobe, one cycle per access |
| wrStb | input | 1 | Write strobe, one cycle per access |
| wrData | input | 8 | CPU write data, also the memory write data |
| rdData | output | 8 | CPU read data, valid during the read cycle |
| vblankStart | input | 1 | Start-of-blank pulse |
| vblankEnd | input | 1 | End-of-blank pulse |
| spr0HitSet | input | 1 | Sprite-zero hit set pulse |
| sprOvfSet | input | 1 | Sprite overflow set pulse |
| vramRdData | input | 8 | Video memory data at `vramAddr` |
| oamRdData | input | 8 | Sprite memory data at `oamAddr` |
| vramWe | output | 1 | Video memory write enable |
| oamWe | output | 1 | Sprite memory write enable |
| vramAddr | output | 15 | Live video-memory address |
| tempAddr | output | 15 | Staging address |
| fineX | output | 3 | Fine horizontal scroll |
| ctrlOut | output | 8 | Control register |
| maskOut | output | 8 | Mask register |
| oamAddr | output | 8 | Sprite memory address |
| holdActive | output | 1 | Start-up lock state |
| nmiOut | output | 1 | Level interrupt request |

## Verification
A toggle left in the wrong phase, whether by the lock or by a status read, shows at once. The next scroll or address write lands in the wrong half of `tempAddr`, or never reaches `vramAddr`, and that is visible one cycle after the write. A read buffer that is stale or not cleared shows up as a wrong byte on the very next data-port read. A bad address step shows in `vramAddr` one cycle after the access.

A flag that is wrongly cleared or wrongly kept shows on the next status read, and through `nmiOut` one cycle after the pulse. An address that reset disturbed shows the moment reset is released.

// File: rtl/vid_reg_pkg.sv
package vid_reg_pkg;
  localparam int DATA_W  = 8;
  localparam int VADDR_W = 15;
  localparam int OAM_AW  = 8;
  localparam int IDX_W   = 3;

  localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd0;
  localparam logic [IDX_W-1:0] IDX_MASK   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STATUS = 3'd2;
  localparam logic [IDX_W-1:0] IDX_OADDR  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_ODATA  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_SCROLL = 3'd5;
  localparam logic [IDX_W-1:0] IDX_ADDR   = 3'd6;
  localparam logic [IDX_W-1:0] IDX_PORT   = 3'd7;

  // One-cycle action strobes from decode to the datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic wrScrollA;
    logic wrScrollB;
    logic wrAddrA;
    logic wrAddrB;
    logic wrOamAddr;
    logic wrOamData;
    logic wrPort;
    logic rdStatus;
    logic rdOamData;
    logic rdPort;
    logic holdOn;
  } regStrobe_t;
endpackage

// File: rtl/vid_reg_ctrl.sv
module vid_reg_ctrl
  import vid_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic             vblankEnd,
  output regStrobe_t       strb,
  output logic             holdActive
);
  logic holdQ;
  logic secondQ;
  logic rdAct;
  logic wrAct;
  logic wrOpen;

  assign rdAct  = rdStb;
  assign wrAct  = wrStb & ~rdStb;
  assign wrOpen = wrAct & ~holdQ;

  // Start-up lock: set by reset, dropped by the first end-of-blank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          holdQ <= 1'b1;
    else if (vblankEnd) holdQ <= 1'b0;
  end

  always_comb begin
    strb        = '0;
    strb.holdOn = holdQ;
    if (rdAct) begin
      unique case (regIdx)
        IDX_STATUS: strb.rdStatus  = 1'b1;
        IDX_ODATA:  strb.rdOamData = 1'b1;
        IDX_PORT:   strb.rdPort    = 1'b1;
        default:    ;
      endcase
    end
    if (wrAct) begin
      unique case (regIdx)
        IDX_OADDR: strb.wrOamAddr = 1'b1;
        IDX_ODATA: strb.wrOamData = 1'b1;
        IDX_PORT:  strb.wrPort    = 1'b1;
        default:   ;
      endcase
    end
    if (wrOpen) begin
      unique case (regIdx)
        IDX_CTRL:   strb.wrCtrl    = 1'b1;
        IDX_MASK:   strb.wrMask    = 1'b1;
        IDX_SCROLL: begin
          strb.wrScrollA = ~secondQ;
          strb.wrScrollB =  secondQ;
        end
        IDX_ADDR:   begin
          strb.wrAddrA = ~secondQ;
          strb.wrAddrB =  secondQ;
        end
        default:    ;
      endcase
    end
  end

  // Shared first/second write toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              secondQ <= 1'b0;
    else if (holdQ)                         secondQ <= 1'b0;
    else if (strb.rdStatus)                 secondQ <= 1'b0;
    else if (strb.wrScrollA | strb.wrAddrA) secondQ <= 1'b1;
    else if (strb.wrScrollB | strb.wrAddrB) secondQ <= 1'b0;
  end

  assign holdActive = holdQ;
endmodule

// File: rtl/vid_reg_dpath.sv
module vid_reg_dpath
  import vid_reg_pkg::*;
#(
  parameter int ROW_STEP = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               vblankStart,
  input  logic               vblankEnd,
  input  logic               spr0HitSet,
  input  logic               sprOvfSet,
  input  logic [DATA_W-1:0]  vramRdData,
  input  logic [DATA_W-1:0]  oamRdData,
  output logic [DATA_W-1:0]  rdData,
  output logic [VADDR_W-1:0] vramAddr,
  output logic [VADDR_W-1:0] tempAddr,
  output logic [2:0]         fineX,
  output logic [DATA_W-1:0]  ctrlOut,
  output logic [DATA_W-1:0]  maskOut,
  output logic [OAM_AW-1:0]  oamAddr,
  output logic [2:0]         flagBits,
  output logic               nmiOut,
  output logic               vramWe,
  output logic               oamWe
);
  localparam logic [VADDR_W-1:0] STEP_COL = VADDR_W'(1);
  localparam logic [VADDR_W-1:0] STEP_ROW = VADDR_W'(ROW_STEP);

  logic [DATA_W-1:0]  ctrlQ, maskQ, bufQ;
  logic [VADDR_W-1:0] tQ, vQ, tNext, vStep;
  logic [2:0]         fxQ;
  logic               blankQ, hitQ, ovfQ;
  logic [OAM_AW-1:0]  oamQ;

  always_comb begin
    tNext = tQ;
    if (strb.wrScrollA) tNext[4:0] = wrData[7:3];
    if (strb.wrScrollB) begin
      tNext[9:5]   = wrData[7:3];
      tNext[14:12] = wrData[2:0];
    end
    if (strb.wrAddrA) begin
      tNext[13:8] = wrData[5:0];
      tNext[14]   = 1'b0;
    end
    if (strb.wrAddrB) tNext[7:0] = wrData;
  end

  assign vStep = ctrlQ[2] ? STEP_ROW : STEP_COL;

  // Configuration registers, cleared while the lock is held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      maskQ <= '0;
      tQ    <= '0;
      fxQ   <= '0;
      bufQ  <= '0;
    end else if (strb.holdOn) begin
      ctrlQ <= '0;
      maskQ <= '0;
      tQ    <= '0;
      fxQ   <= '0;
      bufQ  <= '0;
    end else begin
      if (strb.wrCtrl)    ctrlQ <= wrData;
      if (strb.wrMask)    maskQ <= wrData;
      if (strb.wrScrollA) fxQ   <= wrData[2:0];
      tQ <= tNext;
      if (strb.rdPort)    bufQ  <= vramRdData;
    end
  end

  // Live address has no reset
  always_ff @(posedge clk) begin
    if (strb.wrAddrB)                   vQ <= tNext;
    else if (strb.rdPort | strb.wrPort) vQ <= vQ + vStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankQ <= 1'b0;
      hitQ   <= 1'b0;
      ovfQ   <= 1'b0;
    end else begin
      if (vblankStart)                       blankQ <= 1'b1;
      else if (vblankEnd | strb.rdStatus)    blankQ <= 1'b0;
      if (spr0HitSet)                        hitQ   <= 1'b1;
      else if (vblankEnd)                    hitQ   <= 1'b0;
      if (sprOvfSet)                         ovfQ   <= 1'b1;
      else if (vblankEnd)                    ovfQ   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               oamQ <= '0;
    else if (strb.wrOamAddr) oamQ <= wrData[OAM_AW-1:0];
    else if (strb.wrOamData) oamQ <= oamQ + OAM_AW'(1);
  end

  always_comb begin
    rdData = '0;
    if (strb.rdStatus)       rdData = {blankQ, hitQ, ovfQ, 5'b0};
    else if (strb.rdOamData) rdData = oamRdData;
    else if (strb.rdPort)    rdData = bufQ;
  end

  assign vramAddr = vQ;
  assign tempAddr = tQ;
  assign fineX    = fxQ;
  assign ctrlOut  = ctrlQ;
  assign maskOut  = maskQ;
  assign oamAddr  = oamQ;
  assign flagBits = {blankQ, hitQ, ovfQ};
  assign nmiOut   = blankQ & ctrlQ[7];
  assign vramWe   = strb.wrPort;
  assign oamWe    = strb.wrOamData;
endmodule

// File: rtl/vid_reg_port.sv
module vid_reg_port
  import vid_reg_pkg::*;
#(
  parameter int ROW_STEP = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   regIdx,
  input  logic         rdStb,
  input  logic         wrStb,
  input  logic [7:0]   wrData,
  output logic [7:0]   rdData,
  input  logic         vblankStart,
  input  logic         vblankEnd,
  input  logic         spr0HitSet,
  input  logic         sprOvfSet,
  input  logic [7:0]   vramRdData,
  input  logic [7:0]   oamRdData,
  output logic         vramWe,
  output logic         oamWe,
  output logic [14:0]  vramAddr,
  output logic [14:0]  tempAddr,
  output logic [2:0]   fineX,
  output logic [7:0]   ctrlOut,
  output logic [7:0]   maskOut,
  output logic [7:0]   oamAddr,
  output logic         holdActive,
  output logic         nmiOut
);
  regStrobe_t strb;
  logic [2:0] flagBits;

  vid_reg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regIdx     (regIdx),
    .rdStb      (rdStb),
    .wrStb      (wrStb),
    .vblankEnd  (vblankEnd),
    .strb       (strb),
    .holdActive (holdActive)
  );

  vid_reg_dpath #(.ROW_STEP(ROW_STEP)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .vblankStart (vblankStart),
    .vblankEnd   (vblankEnd),
    .spr0HitSet  (spr0HitSet),
    .sprOvfSet   (sprOvfSet),
    .vramRdData  (vramRdData),
    .oamRdData   (oamRdData),
    .rdData      (rdData),
    .vramAddr    (vramAddr),
    .tempAddr    (tempAddr),
    .fineX       (fineX),
    .ctrlOut     (ctrlOut),
    .maskOut     (maskOut),
    .oamAddr     (oamAddr),
    .flagBits    (flagBits),
    .nmiOut      (nmiOut),
    .vramWe      (vramWe),
    .oamWe       (oamWe)
  );
endmodule

// File: rtl/vid_reg_port_chk.sv
module vid_reg_port_chk #(
  parameter int ROW_STEP = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  regIdx,
  input logic        rdStb,
  input logic        wrStb,
  input logic        vblankStart,
  input logic        vblankEnd,
  input logic        spr0HitSet,
  input logic        sprOvfSet,
  input logic        holdActive,
  input logic [7:0]  ctrlOut,
  input logic [7:0]  maskOut,
  input logic [14:0] tempAddr,
  input logic [2:0]  fineX,
  input logic [14:0] vramAddr,
  input logic [2:0]  flagBits,
  input logic        nmiOut
);
  // R1
  hold_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdActive && vblankEnd |=> !holdActive);
  // R1
  hold_stays_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !holdActive |=> !holdActive);
  // R2
  hold_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |-> (ctrlOut == 8'd0 && maskOut == 8'd0 && tempAddr == 15'd0 && fineX == 3'd0));
  // R6
  blank_read_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStb && regIdx == 3'd2 && !vblankStart |=> !flagBits[2]);
  // R6
  sprite_bits_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStb && regIdx == 3'd2 && !vblankEnd && !spr0HitSet && !sprOvfSet
    |=> flagBits[1:0] == $past(flagBits[1:0]));
  // R5
  end_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    vblankEnd && !vblankStart && !spr0HitSet && !sprOvfSet |=> flagBits == 3'd0);
  // R10
  port_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb && !rdStb && regIdx == 3'd7
    |=> vramAddr == $past(vramAddr) + ($past(ctrlOut[2]) ? 15'(ROW_STEP) : 15'd1));
  // R11
  nmi_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    vblankStart && ctrlOut[7] && !(wrStb && regIdx == 3'd0) |=> nmiOut);
endmodule

bind vid_reg_port vid_reg_port_chk #(.ROW_STEP(ROW_STEP)) u_chk (.*);

// File: tb/vid_reg_port_bench.sv
module vid_reg_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regIdx = '0;
  logic        rdStb = 1'b0, wrStb = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        vblankStart = 1'b0, vblankEnd = 1'b0, spr0HitSet = 1'b0, sprOvfSet = 1'b0;
  logic [7:0]  vramRdData, oamRdData;
  logic        vramWe, oamWe, holdActive, nmiOut;
  logic [14:0] vramAddr, tempAddr;
  logic [2:0]  fineX;
  logic [7:0]  ctrlOut, maskOut, oamAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // Memory models computed from the address
  assign vramRdData = vramAddr[7:0] ^ {1'b0, vramAddr[14:8]};
  assign oamRdData  = ~oamAddr;

  vid_reg_port u_vid_reg_port (.*);

  function automatic logic [7:0] memByte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic weSeen;

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    regIdx = idx; wrData = d; wrStb = 1'b1;
    #1 weSeen = (idx == 3'd7) ? vramWe : oamWe;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] d);
    @(negedge clk);
    regIdx = idx; rdStb = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic pulse(input bit s, input bit e, input bit h, input bit o);
    @(negedge clk);
    vblankStart = s; vblankEnd = e; spr0HitSet = h; sprOvfSet = o;
    @(negedge clk);
    vblankStart = 0; vblankEnd = 0; spr0HitSet = 0; sprOvfSet = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [14:0] expT, expV;
    logic [2:0]  expFx;
    logic [7:0]  expBuf, got;
    expT = '0; expFx = '0; expBuf = '0; expV = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(holdActive == 1'b1, "R1 hold after reset", holdActive, 1);
    check(ctrlOut == 0 && maskOut == 0 && tempAddr == 0 && fineX == 0 && !nmiOut,
          "R2 cleared at reset", {ctrlOut, maskOut}, 0);
    pulse(0, 1, 0, 0);
    check(holdActive == 1'b0, "R1 hold released", holdActive, 0);

    // R8 address write sweep
    for (int h = 0; h < 256; h += 23) begin
      logic [7:0] lo;
      lo = 8'((h * 7 + 5) & 255);
      wr(3'd6, 8'(h));
      expT[13:8] = 6'(h); expT[14] = 1'b0;
      check(tempAddr == expT, "R8 first address write", tempAddr, expT);
      wr(3'd6, lo);
      expT[7:0] = lo; expV = expT;
      check(tempAddr == expT && vramAddr == expV, "R8 second address write", vramAddr, expV);
    end

    // R7 scroll write sweep
    for (int d = 0; d < 256; d += 17) begin
      logic [7:0] b;
      b = 8'(255 - d);
      wr(3'd5, 8'(d));
      expT[4:0] = 5'(d >> 3); expFx = 3'(d);
      check(tempAddr == expT && fineX == expFx, "R7 first scroll write", tempAddr, expT);
      wr(3'd5, b);
      expT[9:5] = b[7:3]; expT[14:12] = b[2:0];
      check(tempAddr == expT && fineX == expFx && vramAddr == expV,
            "R7 second scroll write", tempAddr, expT);
    end

    // R6 status read resets toggle
    wr(3'd5, 8'hF3);
    expT[4:0] = 5'h1E; expFx = 3'd3;
    rd(3'd2, got);
    wr(3'd5, 8'h29);
    expT[4:0] = 5'h05; expFx = 3'd1;
    check(tempAddr == expT && fineX == expFx, "R6 toggle reset by status read", tempAddr, expT);
    wr(3'd5, 8'h00);
    expT[9:5] = 0; expT[14:12] = 0;

    // R9 data port reads with both steps
    wr(3'd6, 8'h21); wr(3'd6, 8'h08);
    expT[13:8] = 6'h21; expT[14] = 0; expT[7:0] = 8'h08; expV = expT;
    for (int pass = 0; pass < 2; pass++) begin
      wr(3'd0, pass == 0 ? 8'h00 : 8'h04);
      for (int i = 0; i < 6; i++) begin
        rd(3'd7, got);
        check(got == expBuf, "R9 buffered read data", got, expBuf);
        expBuf = memByte(expV);
        expV = expV + (pass == 0 ? 15'd1 : 15'd32);
        check(vramAddr == expV, "R9 address step", vramAddr, expV);
      end
    end

    // R10 data port write
    wr(3'd7, 8'h55);
    expV = expV + 15'd32;
    check(weSeen == 1'b1 && vramAddr == expV, "R10 port write step", vramAddr, expV);
    wr(3'd0, 8'h00);
    wr(3'd7, 8'hAA);
    expV = expV + 15'd1;
    check(weSeen == 1'b1 && vramAddr == expV, "R10 port write step by one", vramAddr, expV);

    // R5 / R6 flags
    pulse(1, 0, 1, 1);
    rd(3'd2, got);
    check(got == 8'hE0, "R6 status bits", got, 8'hE0);
    rd(3'd2, got);
    check(got == 8'h60, "R6 only blank cleared", got, 8'h60);
    pulse(0, 1, 0, 0);
    rd(3'd2, got);
    check(got == 8'h00, "R5 end clears flags", got, 0);
    pulse(0, 1, 1, 0);
    rd(3'd2, got);
    check(got == 8'h40, "R5 set wins over end", got, 8'h40);
    pulse(0, 1, 0, 0);

    // R11 interrupt level
    wr(3'd0, 8'h80);
    pulse(1, 0, 0, 0);
    check(nmiOut == 1'b1, "R11 nmi raised", nmiOut, 1);
    wr(3'd0, 8'h00);
    check(nmiOut == 1'b0, "R11 nmi masked by control", nmiOut, 0);
    wr(3'd0, 8'h80);
    check(nmiOut == 1'b1, "R11 nmi unmasked", nmiOut, 1);
    rd(3'd2, got);
    check(nmiOut == 1'b0, "R11 nmi drops on status read", nmiOut, 0);
    wr(3'd0, 8'h00);

    // R12 sprite memory registers and zero reads
    wr(3'd3, 8'h10);
    check(oamAddr == 8'h10, "R12 sprite address load", oamAddr, 8'h10);
    wr(3'd4, 8'h77);
    check(weSeen == 1'b1 && oamAddr == 8'h11, "R12 sprite data write", oamAddr, 8'h11);
    rd(3'd4, got);
    check(got == 8'hEE && oamAddr == 8'h11, "R12 sprite data read", got, 8'hEE);
    for (int k = 0; k < 7; k++) begin
      if (k == 0 || k == 1 || k == 3 || k == 5 || k == 6) begin
        rd(3'(k), got);
        check(got == 8'h00, "R12 write-only reads zero", got, 0);
      end
    end

    // R4 reset keeps the live address
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(vramAddr == expV, "R4 address survives reset", vramAddr, expV);
    check(holdActive == 1'b1, "R1 hold set again", holdActive, 1);
    expBuf = 8'h00;

    // R2 writes dropped during the lock
    wr(3'd0, 8'h84);
    check(ctrlOut == 8'h00, "R2 control dropped", ctrlOut, 0);
    wr(3'd1, 8'h1E);
    check(maskOut == 8'h00, "R2 mask dropped", maskOut, 0);
    wr(3'd5, 8'hFF);
    check(tempAddr == 0 && fineX == 0, "R2 scroll dropped", tempAddr, 0);
    wr(3'd6, 8'h3F);
    wr(3'd6, 8'h12);
    check(tempAddr == 0 && vramAddr == expV, "R2 address dropped", vramAddr, expV);

    // R3 other registers act during the lock
    rd(3'd7, got);
    check(got == 8'h00, "R2 buffer held clear", got, 0);
    expV = expV + 15'd1;
    check(vramAddr == expV, "R3 port read steps in lock", vramAddr, expV);
    wr(3'd7, 8'h01);
    expV = expV + 15'd1;
    check(weSeen == 1'b1 && vramAddr == expV, "R3 port write in lock", vramAddr, expV);
    wr(3'd3, 8'h20);
    check(oamAddr == 8'h20, "R3 sprite address in lock", oamAddr, 8'h20);
    wr(3'd4, 8'h02);
    check(weSeen == 1'b1 && oamAddr == 8'h21, "R3 sprite data in lock", oamAddr, 8'h21);
    pulse(1, 0, 0, 0);
    rd(3'd2, got);
    check(got == 8'h80, "R3 status read in lock", got, 8'h80);

    // Release, then the toggle must start at the first write
    pulse(0, 1, 0, 0);
    check(holdActive == 1'b0, "R1 second release", holdActive, 0);
    rd(3'd7, got);
    check(got == 8'h00, "R2 buffer was cleared", got, 0);
    expV = expV + 15'd1;
    wr(3'd6, 8'h05); wr(3'd6, 8'h67);
    check(vramAddr == 15'h0567 && tempAddr == 15'h0567, "R2 toggle unchanged by dropped writes",
          vramAddr, 15'h0567);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule